// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four pulse-width-modulated outputs from one shared period counter. A power-of-two prescaler divides the system clock to form the counting tick. The counter runs in one of two shapes. In edge mode it counts upward and wraps, which gives edge-aligned pulses. In center mode it counts up to the top value and back down to zero, which gives pulses centred on the period boundary.

Each channel receives a 16-bit compare word. The low 15 bits hold the duty value that is compared with the counter. The top bit flips the output polarity. The top value, the counting shape and all four compare words are copied into shadow registers only at a period boundary. A host can therefore rewrite them at any time without producing a partial pulse. A one-cycle event pulse marks the start of every period.

All inputs are plain control levels. The block has no data stream and no back-pressure. Pin routing and the loading of duty tables sit outside this block.

Top module: `quad_pwm_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every `pwm_out` bit and `period_end` are 0.
- R2: While `enable` is 0, the prescaler and the counter hold at zero, every `pwm_out` bit is 0 whatever the polarity bit, and `period_end` stays 0.
- R3: The counter advances once every 2^`prescale` clock cycles, with `prescale` from 0 to 7.
- R4: In edge mode (`center_mode`=0) the counter runs 0 to top-1 and wraps, so a period lasts top ticks. A top of 0 or 1 gives a one-tick period.
- R5: In center mode (`center_mode`=1) the counter climbs from 0 to top and falls back to 1, so a period lasts 2*top ticks.
- R6: A channel is active while the counter is below its duty value (compare bits 14:0). In edge mode, for 0 < duty < top, a channel is therefore active for duty ticks of each period.
- R7: With compare bit 15 at 0 the active level is 1. With bit 15 at 1 the output is inverted, so it is high for the period length minus the active time.
- R8: A duty value of 0 keeps a channel inactive for the whole period. A nonzero duty value of top or more keeps it active for the whole period, in either mode.
- R9: `period_end` is high for exactly one clock cycle, the first cycle of each period, when the counter is 0. This holds for any period longer than one clock cycle.
- R10: The top value, the counting shape and the compare words are sampled only at a period boundary, or continuously while the block is disabled. A change made mid-period does not alter the running period and takes effect from the next one.
- R11: In center mode, for 0 < duty < top, a channel is active for 2*duty-1 ticks of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 holds it idle |
| prescale | input | 3 | Tick divider exponent: divide by 2^prescale |
| center_mode | input | 1 | 0 = edge-aligned counting, 1 = center-aligned counting |
| top_value | input | 15 | Counter top value |
| cmp_words | input | 64 | Four compare words, channel n in bits [16n+15:16n]; bit 15 of each word is polarity |
| pwm_out | output | 4 | Channel outputs, bit n for channel n |
| period_end | output | 1 | One-cycle pulse in the first cycle of every period |

## Verification
On every cycle, the assertions check the following: the outputs are idle while disabled, and no event follows a disabled cycle. The counter stays within its bound for the active shape. The event coincides with a zero count. The shadowed top value changes only on a boundary or while disabled. The pulse widths, the period lengths for each divider, the polarity inversion and the center-mode active time are shown only by the bench scenarios, which measure whole periods. The same holds for the rule that a mid-period rewrite leaves the current period untouched.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  typedef enum logic { CNT_EDGE = 1'b0, CNT_CENTER = 1'b1 } cnt_shape_e;
  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } cnt_dir_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] mask;

  // mask has sel low ones; tick fires when those bits of the divider are all set
  always_comb begin
    span = ({{DIV_W{1'b0}}, 1'b1} << sel) - {{DIV_W{1'b0}}, 1'b1};
    mask = span[DIV_W-1:0];
    tick = run && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!run) div_q <= '0;
    else          div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import quad_pwm_pkg::*;
#(
  parameter int VAL_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [VAL_W-1:0] top_in,
  input  cnt_shape_e       shape_in,
  output logic [VAL_W-1:0] cnt,
  output logic [VAL_W-1:0] act_top,
  output cnt_shape_e       act_shape,
  output logic             load,
  output logic             period_end
);
  localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

  cnt_dir_e         dir_q, dir_nxt;
  logic [VAL_W-1:0] nxt;
  logic             wrap;

  always_comb begin
    nxt     = cnt;
    dir_nxt = dir_q;
    if (act_shape == CNT_EDGE) begin
      if (act_top <= ONE || cnt == act_top - ONE) nxt = '0;
      else                                       nxt = cnt + ONE;
      dir_nxt = DIR_UP;
    end else begin
      if (act_top == '0)                     nxt = '0;
      else if (dir_q == DIR_UP && cnt < act_top) nxt = cnt + ONE;
      else                                   nxt = cnt - ONE;
      if (nxt == '0)                               dir_nxt = DIR_UP;
      else if (dir_q == DIR_UP && cnt >= act_top)  dir_nxt = DIR_DOWN;
    end
  end

  assign wrap = tick && (nxt == '0);
  assign load = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      dir_q      <= DIR_UP;
      act_top    <= '0;
      act_shape  <= CNT_EDGE;
      period_end <= 1'b0;
    end else if (!run) begin
      cnt        <= '0;
      dir_q      <= DIR_UP;
      act_top    <= top_in;
      act_shape  <= shape_in;
      period_end <= 1'b0;
    end else begin
      period_end <= wrap;
      if (tick) begin
        cnt   <= nxt;
        dir_q <= dir_nxt;
      end
      if (wrap) begin
        act_top   <= top_in;
        act_shape <= shape_in;
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [DATA_W-1:0] word_in,
  input  logic [DATA_W-2:0] cnt,
  input  logic [DATA_W-2:0] act_top,
  output logic              out
);
  localparam int VAL_W = DATA_W - 1;

  logic [DATA_W-1:0] word_q;
  logic [VAL_W-1:0]  duty;
  logic              invert;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  always_comb begin
    duty   = word_q[VAL_W-1:0];
    invert = word_q[DATA_W-1];
    active = (duty != '0) && ((duty >= act_top) || (cnt < duty));
    out    = run && (active ^ invert);
  end
endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen
  import quad_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int PRE_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [PRE_W-1:0]         prescale,
  input  logic                     center_mode,
  input  logic [DATA_W-2:0]        top_value,
  input  logic [NUM_CH*DATA_W-1:0] cmp_words,
  output logic [NUM_CH-1:0]        pwm_out,
  output logic                     period_end
);
  localparam int VAL_W = DATA_W - 1;

  logic             tick;
  logic             load;
  logic [VAL_W-1:0] cnt;
  logic [VAL_W-1:0] act_top;
  cnt_shape_e       act_shape;
  cnt_shape_e       shape_in;

  assign shape_in = center_mode ? CNT_CENTER : CNT_EDGE;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enable), .sel(prescale), .tick(tick)
  );

  pwm_timebase #(.VAL_W(VAL_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick),
    .top_in(top_value), .shape_in(shape_in),
    .cnt(cnt), .act_top(act_top), .act_shape(act_shape),
    .load(load), .period_end(period_end)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(enable), .load(load),
      .word_in(cmp_words[g*DATA_W +: DATA_W]),
      .cnt(cnt), .act_top(act_top), .out(pwm_out[g])
    );
  end
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk
  import quad_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VAL_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [NUM_CH-1:0] pwm_out,
  input logic              period_end,
  input logic [VAL_W-1:0]  cnt,
  input logic [VAL_W-1:0]  act_top,
  input cnt_shape_e        act_shape
);
  localparam logic [VAL_W-1:0] ONE = {{(VAL_W-1){1'b0}}, 1'b1};

  a_r2_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> pwm_out == '0);

  a_r2_no_event_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !period_end);

  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act_shape == CNT_EDGE && act_top > ONE) |-> cnt < act_top);

  a_r5_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && act_shape == CNT_CENTER) |-> cnt <= act_top);

  a_r9_event_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> cnt == '0);

  a_r10_top_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !period_end) |-> $stable(act_top));
endmodule

bind quad_pwm_gen quad_pwm_chk #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_out(pwm_out),
  .period_end(period_end), .cnt(cnt), .act_top(act_top), .act_shape(act_shape)
);

// File: tb/tb_quad_pwm_gen.sv
module tb_quad_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  prescale = '0;
  logic        center_mode = 1'b0;
  logic [14:0] top_value = '0;
  logic [63:0] cmp_words = '0;
  logic [3:0]  pwm_out;
  logic        period_end;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int m_per, m_pe;
  int m_hi[4];

  always #10 clk = ~clk;

  quad_pwm_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
    .center_mode(center_mode), .top_value(top_value), .cmp_words(cmp_words),
    .pwm_out(pwm_out), .period_end(period_end)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cmp(input logic [15:0] c0, input logic [15:0] c1,
                         input logic [15:0] c2, input logic [15:0] c3);
    cmp_words = {c3, c2, c1, c0};
  endtask

  // count one whole period starting at a fresh period_end pulse
  task automatic measure();
    while (period_end) @(negedge clk);
    while (!period_end) @(negedge clk);
    m_per = 0; m_pe = 0;
    for (int i = 0; i < 4; i++) m_hi[i] = 0;
    do begin
      for (int i = 0; i < 4; i++) m_hi[i] += int'(pwm_out[i]);
      m_pe += int'(period_end);
      m_per++;
      @(negedge clk);
    end while (!period_end);
  endtask

  task automatic t_reset();
    check("R1", "outputs in reset", int'(pwm_out), 0);
    check("R1", "event in reset", int'(period_end), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", int'(pwm_out), 0);
    check("R1", "event after reset", int'(period_end), 0);
  endtask

  task automatic t_disabled();
    int seen_out = 0, seen_pe = 0;
    enable = 1'b0; top_value = 15'd5;
    set_cmp(16'h8000, 16'h8003, 16'h0007, 16'h0002);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      seen_out |= int'(pwm_out);
      seen_pe  |= int'(period_end);
    end
    check("R2", "outputs idle while disabled", seen_out, 0);
    check("R2", "no event while disabled", seen_pe, 0);
  endtask

  task automatic t_edge_basic();
    prescale = 3'd0; center_mode = 1'b0; top_value = 15'd10;
    set_cmp(16'd3, 16'd0, 16'd10, 16'h8004);
    enable = 1'b1;
    measure();
    check("R4", "edge period", m_per, 10);
    check("R6", "edge duty 3", m_hi[0], 3);
    check("R8", "duty 0 never active", m_hi[1], 0);
    check("R8", "duty at top always active", m_hi[2], 10);
    check("R7", "inverted duty 4", m_hi[3], 6);
    check("R9", "one event cycle per period", m_pe, 1);
  endtask

  task automatic t_center();
    prescale = 3'd1; center_mode = 1'b1; top_value = 15'd5;
    set_cmp(16'd2, 16'd5, 16'd0, 16'h8003);
    measure();
    check("R5", "center period", m_per, 20);
    check("R11", "center duty 2", m_hi[0], 6);
    check("R8", "center duty at top", m_hi[1], 20);
    check("R8", "center duty 0", m_hi[2], 0);
    check("R7", "center inverted duty 3", m_hi[3], 10);
    check("R9", "center one event cycle", m_pe, 1);
  endtask

  task automatic t_midperiod();
    int per, hi;
    prescale = 3'd0; center_mode = 1'b0; top_value = 15'd20;
    set_cmp(16'd5, 16'd0, 16'd0, 16'd0);
    measure();
    while (!period_end) @(negedge clk);
    per = 0; hi = 0;
    do begin
      if (per == 3) begin
        top_value = 15'd8;
        set_cmp(16'd15, 16'd0, 16'd0, 16'd0);
      end
      hi += int'(pwm_out[0]);
      per++;
      @(negedge clk);
    end while (!period_end);
    check("R10", "period kept after mid change", per, 20);
    check("R10", "duty kept after mid change", hi, 5);
    per = 0; hi = 0;
    do begin
      hi += int'(pwm_out[0]);
      per++;
      @(negedge clk);
    end while (!period_end);
    check("R10", "new period applied", per, 8);
    check("R8", "duty above top always active", hi, 8);
  endtask

  task automatic t_prescale();
    center_mode = 1'b0;
    prescale = 3'd2; top_value = 15'd1; set_cmp(16'd0, 16'd0, 16'd0, 16'd0);
    measure();
    check("R4", "top 1 gives one-tick period", m_per, 4);
    prescale = 3'd3; top_value = 15'd6; set_cmp(16'd2, 16'd0, 16'd0, 16'd0);
    measure();
    check("R3", "divide by 8 period", m_per, 48);
    check("R3", "divide by 8 duty", m_hi[0], 16);
    prescale = 3'd7; top_value = 15'd3; set_cmp(16'd1, 16'd0, 16'd0, 16'd0);
    measure();
    check("R3", "divide by 128 period", m_per, 384);
    check("R3", "divide by 128 duty", m_hi[0], 128);
  endtask

  task automatic t_disable_again();
    enable = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2", "outputs idle after disable", int'(pwm_out), 0);
    check("R2", "no event after disable", int'(period_end), 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_edge_basic();
    t_center();
    t_midperiod();
    t_prescale();
    t_disable_again();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule